// File: doc/BRIEF.md
# Cascadable Timer/Counter with Input Capture

This block holds two 8-bit up-counters that share one free-running prescaler. Each counter advances on a selected prescaler tap. Counter 0 can instead advance on rising edges of an external event pin. Each counter has a compare register. When a counter equals its compare value on an advancing tick, it wraps to zero and sends a one-cycle interrupt pulse. A compare value of N therefore gives a period of N+1 ticks.

Setting a join bit chains the two counters into one 16-bit timer. The compare value is then split: compare register 0 holds the low byte and compare register 1 holds the high byte. Only interrupt 0 fires in this mode.

In capture mode the counter keeps running. The chosen edge on a capture pin copies the live count into a capture register. In joined mode both bytes are copied on the same clock edge.

Software reaches the block through a small register port. The address is shared between reads and writes. Each counter has its own enable pin.

Top module: `cascade_timer`

## Requirements
- R1: After reset every register reads 0 and both interrupts are low. The register map is 0 CMP0, 1 CMP1, 2 CTL0, 3 CTL1, 4 CNT0, 5 CNT1, 6 CAP0, 7 CAP1. Addresses 0 to 3 read back what was written.
- R2: The CTL0 bits [2:0] select the counter 0 tick. Values 0 to 5 divide the clock by 2 to 64, 6 divides by 256 and 7 divides by 1024. The CTL1 bits [3:0] with values 0 to 7 give counter 1 the same taps.
- R3: CTL1 values 8, 9, 10 and 11 give counter 1 the fast taps: divide by 1, 2, 4 and 8. Values 12 to 15 also divide by 1.
- R4: A compare value N gives a period of N+1 ticks. When the counter equals its compare value on a tick, it returns to 0 on that tick, and its interrupt is high for exactly that one cycle.
- R5: While a counter's enable pin is low, the counter holds 0 and ignores ticks. Raising the enable starts the count from 0.
- R6: With CTL0 bit 3 set, counter 0 advances once per rising edge of `evt_in`. The input passes through a two-flop synchronizer first.
- R7: With capture bit 4 set in a timer's control register, the chosen edge of its capture pin copies the live count into its capture register. Bit 5 selects the edge: 1 means rising, 0 means falling. The other edge leaves the capture register unchanged.
- R8: With CTL0 bit 6 set, the two counters form one 16-bit counter. It is compared against {CMP1,CMP0}, runs from counter 0's tick source and `en0`, and raises only `irq0`. `irq1` stays low.
- R9: In joined capture mode, an edge on `cap0_in` loads CAP0 and CAP1 with the low and high count bytes on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| en0 | input | 1 | Counter 0 run enable (also the enable for the joined counter) |
| en1 | input | 1 | Counter 1 run enable |
| evt_in | input | 1 | External event pin for counter 0 |
| cap0_in | input | 1 | Capture pin for counter 0 (and for the joined counter) |
| cap1_in | input | 1 | Capture pin for counter 1 |
| irq0 | output | 1 | Counter 0 or joined-counter match pulse |
| irq1 | output | 1 | Counter 1 match pulse |

## Verification
The bench measures the distance between match pulses for every prescaler tap class.

- **Off-by-one period.** A design that compares one count too late or too early would show periods of N or N+2 ticks instead of N+1.
- **Joined mode.** The bench checks a 16-bit period that needs a carry at low byte 0xFF. It also checks that `irq1` stays silent. A design with the wrong byte order or a lost carry gives the wrong period.
- **Event counting across the compare value.** Pulses are counted up to and across the compare value. This catches a missed wrap and a double count from an unsynchronized edge.
- **Capture polarity, coherence and enable.** Edges of the wrong polarity must leave the capture register unchanged. The two bytes of a 16-bit capture must agree. Ticks must be ignored while the enable is low.

// File: rtl/ctmr_pkg.sv
`timescale 1ns/1ps
package ctmr_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int PRE_W  = 10;
    localparam int SH_W   = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_CMP0 = 3'd0,
        A_CMP1 = 3'd1,
        A_CTL0 = 3'd2,
        A_CTL1 = 3'd3,
        A_CNT0 = 3'd4,
        A_CNT1 = 3'd5,
        A_CAP0 = 3'd6,
        A_CAP1 = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic       spare;
        logic       join16;
        logic       cap_rise;
        logic       cap_mode;
        logic       src_evt;
        logic [2:0] rate;
    } ctl0_t;

    typedef struct packed {
        logic [1:0] spare;
        logic       cap_rise;
        logic       cap_mode;
        logic [3:0] rate;
    } ctl1_t;

    // Counter 0 tap: clock divide as a power of two
    function automatic logic [SH_W-1:0] rate0_shift(input logic [2:0] r);
        case (r)
            3'd6:    return SH_W'(8);
            3'd7:    return SH_W'(10);
            default: return SH_W'(r) + SH_W'(1);
        endcase
    endfunction

    // Counter 1 tap: shared slow taps plus fast divide-by-1..8 taps
    function automatic logic [SH_W-1:0] rate1_shift(input logic [3:0] r);
        if (!r[3])
            return rate0_shift(r[2:0]);
        else if (!r[2])
            return SH_W'(r[1:0]);
        else
            return '0;
    endfunction

endpackage

// File: rtl/ctmr_prescaler.sv
`timescale 1ns/1ps
module ctmr_prescaler
    import ctmr_pkg::*;
#(
    parameter int PW = PRE_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [SH_W-1:0] sh0,
    input  logic [SH_W-1:0] sh1,
    output logic            tick0,
    output logic            tick1
);

    logic [PW-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_q + PW'(1);
    end

    function automatic logic tap_hit(input logic [PW-1:0] p, input logic [SH_W-1:0] sh);
        logic [PW-1:0] mask;
        mask = (PW'(1) << sh) - PW'(1);
        return &(p | ~mask);
    endfunction

    always_comb begin
        tick0 = tap_hit(pre_q, sh0);
        tick1 = tap_hit(pre_q, sh1);
    end

endmodule

// File: rtl/ctmr_edge_sync.sv
`timescale 1ns/1ps
module ctmr_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic rise_sel,
    output logic hit
);

    logic s1_q, s2_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            s1_q   <= din;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    always_comb hit = rise_sel ? (s2_q & ~prev_q) : (~s2_q & prev_q);

endmodule

// File: rtl/ctmr_counter.sv
`timescale 1ns/1ps
module ctmr_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         step,
    input  logic         wrap,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (step)
            cnt <= wrap ? '0 : cnt + W'(1);
    end

endmodule

// File: rtl/cascade_timer.sv
`timescale 1ns/1ps
module cascade_timer
    import ctmr_pkg::*;
#(
    parameter int PW = PRE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              en0,
    input  logic              en1,
    input  logic              evt_in,
    input  logic              cap0_in,
    input  logic              cap1_in,
    output logic              irq0,
    output logic              irq1
);

    localparam int NCAP = 2;

    logic [DATA_W-1:0] cmp0_q, cmp1_q, cap0_q, cap1_q;
    ctl0_t             ctl0_q;
    ctl1_t             ctl1_q;
    logic [DATA_W-1:0] cnt0, cnt1;

    // register file
    always_ff @(posedge clk) begin
        if (rst) begin
            cmp0_q <= '0;
            cmp1_q <= '0;
            ctl0_q <= '0;
            ctl1_q <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(addr))
                A_CMP0:  cmp0_q <= wr_data;
                A_CMP1:  cmp1_q <= wr_data;
                A_CTL0:  ctl0_q <= ctl0_t'(wr_data);
                A_CTL1:  ctl1_q <= ctl1_t'(wr_data);
                default: ;
            endcase
        end
    end

    always_comb begin
        case (reg_addr_e'(addr))
            A_CMP0:  rd_data = cmp0_q;
            A_CMP1:  rd_data = cmp1_q;
            A_CTL0:  rd_data = DATA_W'(ctl0_q);
            A_CTL1:  rd_data = DATA_W'(ctl1_q);
            A_CNT0:  rd_data = cnt0;
            A_CNT1:  rd_data = cnt1;
            A_CAP0:  rd_data = cap0_q;
            default: rd_data = cap1_q;
        endcase
    end

    // tick sources
    logic ptick0, ptick1, evt_rise;

    ctmr_prescaler #(.PW(PW)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .sh0   (rate0_shift(ctl0_q.rate)),
        .sh1   (rate1_shift(ctl1_q.rate)),
        .tick0 (ptick0),
        .tick1 (ptick1)
    );

    ctmr_edge_sync u_evt (
        .clk      (clk),
        .rst      (rst),
        .din      (evt_in),
        .rise_sel (1'b1),
        .hit      (evt_rise)
    );

    // capture pin edge detectors, one per counter
    logic [NCAP-1:0] cap_pin, cap_pol, cap_hit;
    assign cap_pin = {cap1_in, cap0_in};
    assign cap_pol = {ctl1_q.cap_rise, ctl0_q.cap_rise};

    for (genvar g = 0; g < NCAP; g++) begin : g_cap
        ctmr_edge_sync u_cap (
            .clk      (clk),
            .rst      (rst),
            .din      (cap_pin[g]),
            .rise_sel (cap_pol[g]),
            .hit      (cap_hit[g])
        );
    end

    // counter control
    logic t0, m0, m1, m16;
    logic clr0, clr1, step0, step1, wrap0, wrap1, fire0, fire1;

    always_comb begin
        t0  = ctl0_q.src_evt ? evt_rise : ptick0;
        m0  = (cnt0 == cmp0_q);
        m1  = (cnt1 == cmp1_q);
        m16 = m0 && m1;
        clr0  = !en0;
        step0 = t0;
        if (ctl0_q.join16) begin
            wrap0 = m16;
            clr1  = !en0;
            step1 = t0 && (m16 || (cnt0 == '1));
            wrap1 = m16;
            fire0 = en0 && t0 && m16;
            fire1 = 1'b0;
        end else begin
            wrap0 = m0;
            clr1  = !en1;
            step1 = ptick1;
            wrap1 = m1;
            fire0 = en0 && t0 && m0;
            fire1 = en1 && ptick1 && m1;
        end
    end

    ctmr_counter #(.W(DATA_W)) u_cnt0 (
        .clk(clk), .rst(rst), .clear(clr0), .step(step0), .wrap(wrap0), .cnt(cnt0)
    );

    ctmr_counter #(.W(DATA_W)) u_cnt1 (
        .clk(clk), .rst(rst), .clear(clr1), .step(step1), .wrap(wrap1), .cnt(cnt1)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq0 <= 1'b0;
            irq1 <= 1'b0;
        end else begin
            irq0 <= fire0;
            irq1 <= fire1;
        end
    end

    // capture registers
    always_ff @(posedge clk) begin
        if (rst) begin
            cap0_q <= '0;
            cap1_q <= '0;
        end else begin
            if (ctl0_q.cap_mode && cap_hit[0]) begin
                cap0_q <= cnt0;
                if (ctl0_q.join16) cap1_q <= cnt1;
            end
            if (!ctl0_q.join16 && ctl1_q.cap_mode && cap_hit[1])
                cap1_q <= cnt1;
        end
    end

    // named taps for the bound checker
    logic join16_w, cap_mode0_w, cap_mode1_w;
    assign join16_w    = ctl0_q.join16;
    assign cap_mode0_w = ctl0_q.cap_mode;
    assign cap_mode1_w = ctl1_q.cap_mode;

endmodule

// File: rtl/ctmr_checker.sv
`timescale 1ns/1ps
module ctmr_checker
    import ctmr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              en0,
    input logic              en1,
    input logic              join16,
    input logic              cap_mode0,
    input logic              cap_mode1,
    input logic              irq0,
    input logic              irq1,
    input logic [DATA_W-1:0] cnt0,
    input logic [DATA_W-1:0] cnt1,
    input logic [DATA_W-1:0] cap0,
    input logic [DATA_W-1:0] cap1
);

    logic pv_q;
    always_ff @(posedge clk) begin
        if (rst) pv_q <= 1'b0;
        else     pv_q <= 1'b1;
    end

    // R4: a match pulse coincides with the counter back at zero
    a_r4_irq0_wraps: assert property (@(posedge clk) disable iff (rst)
        irq0 |-> (cnt0 == '0));
    a_r4_irq1_wraps: assert property (@(posedge clk) disable iff (rst)
        irq1 |-> (cnt1 == '0));

    // R4: counter 0 moves by at most one step or wraps
    a_r4_step_one: assert property (@(posedge clk) disable iff (rst)
        (pv_q && en0 && !join16) |=>
            (cnt0 == $past(cnt0)) || (cnt0 == $past(cnt0) + 8'd1) || (cnt0 == '0));

    // R5: disabled counters sit at zero
    a_r5_hold_zero0: assert property (@(posedge clk) disable iff (rst)
        (pv_q && !en0) |=> (cnt0 == '0));
    a_r5_hold_zero1: assert property (@(posedge clk) disable iff (rst)
        (pv_q && !en1 && !join16) |=> (cnt1 == '0));

    // R8: joined mode keeps interrupt 1 quiet
    a_r8_no_irq1: assert property (@(posedge clk) disable iff (rst)
        (pv_q && join16 && $past(join16)) |-> !irq1);

    // R7: capture registers change only in capture mode
    a_r7_cap0_mode: assert property (@(posedge clk) disable iff (rst)
        (pv_q && !$stable(cap0)) |-> $past(cap_mode0));
    // R9: joined capture writes the high byte only through timer 0's capture
    a_r9_cap1_mode: assert property (@(posedge clk) disable iff (rst)
        (pv_q && !$stable(cap1)) |->
            ($past(join16) ? $past(cap_mode0) : $past(cap_mode1)));

endmodule

bind cascade_timer ctmr_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .en0       (en0),
    .en1       (en1),
    .join16    (join16_w),
    .cap_mode0 (cap_mode0_w),
    .cap_mode1 (cap_mode1_w),
    .irq0      (irq0),
    .irq1      (irq1),
    .cnt0      (cnt0),
    .cnt1      (cnt1),
    .cap0      (cap0_q),
    .cap1      (cap1_q)
);

// File: tb/cascade_timer_tb_top.sv
`timescale 1ns/1ps
module cascade_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       en0 = 1'b0, en1 = 1'b0;
    logic       evt_in = 1'b0, cap0_in = 1'b0, cap1_in = 1'b0;
    logic       irq0, irq1;

    int n_chk = 0;
    int n_bad = 0;
    int irq0_total = 0;
    int irq1_total = 0;

    always #2.5 clk = ~clk;

    cascade_timer dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .en0(en0), .en1(en1), .evt_in(evt_in),
        .cap0_in(cap0_in), .cap1_in(cap1_in), .irq0(irq0), .irq1(irq1)
    );

    always @(negedge clk) begin
        if (irq0) irq0_total++;
        if (irq1) irq1_total++;
    end

    // {counter1 select, rate, compare, expected period in clocks}
    localparam logic [28:0] VEC [8] = '{
        {1'b1, 4'd8,  8'd4, 16'd5},
        {1'b1, 4'd9,  8'd4, 16'd10},
        {1'b1, 4'd11, 8'd2, 16'd24},
        {1'b1, 4'd10, 8'd0, 16'd4},
        {1'b1, 4'd5,  8'd1, 16'd128},
        {1'b0, 4'd0,  8'd3, 16'd8},
        {1'b0, 4'd7,  8'd0, 16'd1024},
        {1'b0, 4'd6,  8'd2, 16'd768}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int d);
        @(negedge clk);
        addr = a;
        #1;
        d = int'(rd_data);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); evt_in = 1'b1;
            @(negedge clk);
            @(negedge clk); evt_in = 1'b0;
            @(negedge clk);
        end
        wait_cyc(4);
    endtask

    task automatic restart0();
        @(negedge clk); en0 = 1'b0;
        wait_cyc(2);
        en0 = 1'b1;
    endtask

    task automatic measure(input logic which, output int per);
        int guard;
        guard = 0;
        per = 0;
        do begin @(negedge clk); guard++; end
        while (!(which ? irq1 : irq0) && guard < 4000);
        do begin @(negedge clk); per++; end
        while (!(which ? irq1 : irq0) && per < 4000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int v, per, i0, i1;
        wait_cyc(3);
        rst = 1'b0;

        // R1: reset state
        check("R1 irq0 after reset", int'(irq0), 0);
        check("R1 irq1 after reset", int'(irq1), 0);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R1 register reset value", v, 0);
        end

        // R1: read back
        wr(3'd0, 8'hA5); rd(3'd0, v); check("R1 CMP0 read back", v, 'hA5);
        wr(3'd1, 8'h3C); rd(3'd1, v); check("R1 CMP1 read back", v, 'h3C);
        wr(3'd3, 8'h9B); rd(3'd3, v); check("R1 CTL1 read back", v, 'h9B);
        wr(3'd6, 8'h77); rd(3'd6, v); check("R1 CAP0 not writable", v, 0);

        // R2 R3 R4: period table
        for (int k = 0; k < 8; k++) begin
            logic [28:0] e;
            e = VEC[k];
            @(negedge clk); en0 = 1'b0; en1 = 1'b0;
            if (e[28]) begin
                wr(3'd3, {4'd0, e[27:24]});
                wr(3'd1, e[23:16]);
                @(negedge clk); en1 = 1'b1;
            end else begin
                wr(3'd2, {5'd0, e[26:24]});
                wr(3'd0, e[23:16]);
                @(negedge clk); en0 = 1'b1;
            end
            measure(e[28], per);
            check(e[28] ? "R3 R4 counter 1 tap period" : "R2 R4 counter 0 tap period",
                  per, int'(e[15:0]));
        end
        @(negedge clk); en0 = 1'b0; en1 = 1'b0;

        // R5: disabled counter ignores events
        wr(3'd2, 8'h08);
        wr(3'd0, 8'hFF);
        pulses(5);
        rd(3'd4, v); check("R5 held at zero while disabled", v, 0);
        @(negedge clk); en0 = 1'b1;
        pulses(3);
        rd(3'd4, v); check("R5 counts from zero after enable", v, 3);

        // R6: event counting up to and across compare 99
        wr(3'd0, 8'd99);
        restart0();
        i0 = irq0_total;
        pulses(99);
        rd(3'd4, v); check("R6 count after 99 edges", v, 99);
        check("R6 no irq before wrap", irq0_total - i0, 0);
        pulses(1);
        rd(3'd4, v); check("R6 R4 wrap on 100th edge", v, 0);
        check("R6 R4 one irq0 pulse per period", irq0_total - i0, 1);

        // R7: capture on rising, ignore falling, then the reverse
        wr(3'd0, 8'hFF);
        wr(3'd2, 8'h38);
        restart0();
        pulses(7);
        @(negedge clk); cap0_in = 1'b1;
        wait_cyc(5);
        rd(3'd6, v); check("R7 rising capture", v, 7);
        pulses(2);
        rd(3'd6, v); check("R7 capture holds without edge", v, 7);
        wr(3'd2, 8'h18);
        @(negedge clk); cap0_in = 1'b0;
        wait_cyc(5);
        rd(3'd6, v); check("R7 falling capture", v, 9);
        pulses(1);
        @(negedge clk); cap0_in = 1'b1;
        wait_cyc(5);
        rd(3'd6, v); check("R7 rising edge ignored in falling mode", v, 9);
        @(negedge clk); cap0_in = 1'b0;
        wait_cyc(5);
        rd(3'd6, v); check("R7 next falling capture", v, 10);

        // R8: joined 16-bit period, compare 0x0103 at divide 2
        @(negedge clk); en0 = 1'b0;
        wr(3'd2, 8'h40);
        wr(3'd0, 8'h03);
        wr(3'd1, 8'h01);
        i1 = irq1_total;
        @(negedge clk); en0 = 1'b1;
        measure(1'b0, per);
        check("R8 joined period", per, 520);
        check("R8 irq1 silent when joined", irq1_total - i1, 0);

        // R9: coherent 16-bit capture of count 300
        wr(3'd0, 8'hFF);
        wr(3'd1, 8'hFF);
        wr(3'd2, 8'h78);
        restart0();
        pulses(300);
        rd(3'd4, v); check("R9 R8 joined low byte carry", v, 'h2C);
        rd(3'd5, v); check("R9 R8 joined high byte", v, 'h01);
        @(negedge clk); cap0_in = 1'b1;
        wait_cyc(5);
        rd(3'd6, v); check("R9 captured low byte", v, 'h2C);
        rd(3'd7, v); check("R9 captured high byte", v, 'h01);
        check("R8 irq1 silent in joined capture", irq1_total - i1, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule